// File: doc/BRIEF.md
# Single-Wire Pulse-Count Configuration Decoder

This block turns bursts of pulses on one control line into settings for a display power stage. A host sends a burst of pulses. The block counts the rising edges in the burst. Once the line has stayed high for a store window, the count is committed. The range the count falls in picks the setting it writes: the negative rail level, the auxiliary positive rail level, the main positive rail level, the main rail current limit, the auxiliary rail current limit, the fast-discharge enable, and the low-margin detection enable. The same count also gives the value written.

The first rising edge seen while the block is off is not counted. It raises the rail enable flag and starts an initialization window, and edges inside that window are ignored. Holding the line low for the shutdown window drops the enable and returns the main and negative rail settings to their defaults. While the block is off, a low auxiliary enable input returns every setting to its default. Both inputs arrive already synchronized, and all timing is counted in ticks of a one-microsecond strobe.

Top module: `pulse_cfg_decoder`

## Requirements
- R1: A burst is committed one clock after the line has been high for STORE_US ticks since its last rising edge, provided at least one edge was counted in the run state; the count then restarts at zero.
- R2: Counts 1 to 51 set `neg_code_o` to the count (1 = most negative level, 0.1 V steps); default 25.
- R3: Counts 52 to 79 set `aux_code_o` to count minus 52 (0 = lowest level, 0.1 V steps); default 8.
- R4: Count 80 sets `fd_en_o` to 1 and count 81 clears it; default 1.
- R5: Count 82 sets `det_en_o` to 1 and count 83 clears it; default 0.
- R6: Counts 84 to 90 set `pos_code_o` to count minus 84; default 0.
- R7: Counts 91 to 97 set `pos_ilim_o` to count minus 91 (0 = lowest limit); default 6.
- R8: Counts 98 to 104 set `aux_ilim_o` to count minus 98; default 4.
- R9: A burst whose count is above 104 changes no output. The edge counter saturates at 127 and does not wrap, so a burst of 130 edges changes nothing either.
- R10: A rising edge while off sets `rail_en_o` one clock later. Edges during the next INIT_US ticks are not counted.
- R11: After the line has been low for OFF_US ticks, `rail_en_o` falls and `neg_code_o`, `pos_code_o` and `pos_ilim_o` return to their defaults, while the other settings are kept. A shorter low time is an ordinary pulse gap.
- R12: While off, a low `aux_en_i` returns every setting to its default within one clock.
- R13: After reset, every setting holds its default and `rail_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle strobe every microsecond |
| ctrl_i | input | 1 | Synchronized pulse control line |
| aux_en_i | input | 1 | Synchronized auxiliary rail enable |
| neg_code_o | output | 6 | Negative rail level code |
| aux_code_o | output | 5 | Auxiliary rail level code |
| pos_code_o | output | 3 | Main positive rail level code |
| pos_ilim_o | output | 3 | Main rail current-limit code |
| aux_ilim_o | output | 3 | Auxiliary rail current-limit code |
| fd_en_o | output | 1 | Fast-discharge enable |
| det_en_o | output | 1 | Low-margin detection enable |
| rail_en_o | output | 1 | Main and negative rail enable |

## Verification
The enable flag is due one clock after the enabling edge. A committed setting is due one clock after the store timer reaches STORE_US ticks, which is roughly 2*STORE_US+1 clocks after the last edge when a tick comes every other clock. Shutdown resets follow the clock after the low timer reaches OFF_US ticks, and the auxiliary-enable reset follows the clock after the block enters the off state. The bench model advances on each rising edge with the same one-register latency for every output and compares on the falling edge, and the directed checks sample with generous margin after each of these instants.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int CNT_W = 7;
  localparam int NEG_W = 6;
  localparam int AUX_W = 5;
  localparam int SEL_W = 3;

  localparam int NEG_LO  = 1;
  localparam int NEG_HI  = 51;
  localparam int AUX_LO  = 52;
  localparam int AUX_HI  = 79;
  localparam int FD_ON   = 80;
  localparam int FD_OFF  = 81;
  localparam int DET_ON  = 82;
  localparam int DET_OFF = 83;
  localparam int POS_LO  = 84;
  localparam int POS_HI  = 90;
  localparam int PIL_LO  = 91;
  localparam int PIL_HI  = 97;
  localparam int AIL_LO  = 98;
  localparam int AIL_HI  = 104;

  localparam int NEG_DEF = 25;
  localparam int AUX_DEF = 8;
  localparam int POS_DEF = 0;
  localparam int PIL_DEF = 6;
  localparam int AIL_DEF = 4;
  localparam bit FD_DEF  = 1'b1;
  localparam bit DET_DEF = 1'b0;

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_INIT = 2'd1, ST_RUN = 2'd2} state_e;
endpackage

// File: rtl/pcd_level_timer.sv
module pcd_level_timer #(
  parameter int LIMIT = 40,
  parameter bit LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic full_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (line_i != LEVEL)          cnt_q <= '0;
    else if (tick_i && !full_o)        cnt_q <= cnt_q + W'(1);
  end

  assign full_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/pcd_pulse_cnt.sv
module pcd_pulse_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // saturates instead of wrapping
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && inc_i && !clr_i) |=> cnt_q == MAX);
endmodule

// File: rtl/pcd_cfg_regs.sv
module pcd_cfg_regs
  import pcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_all_i,
  input  logic             rst_part_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [NEG_W-1:0] neg_code_o,
  output logic [AUX_W-1:0] aux_code_o,
  output logic [SEL_W-1:0] pos_code_o,
  output logic [SEL_W-1:0] pos_ilim_o,
  output logic [SEL_W-1:0] aux_ilim_o,
  output logic             fd_en_o,
  output logic             det_en_o
);
  int c;
  assign c = int'(cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || rst_all_i) begin
      neg_code_o <= NEG_W'(NEG_DEF);
      aux_code_o <= AUX_W'(AUX_DEF);
      pos_code_o <= SEL_W'(POS_DEF);
      pos_ilim_o <= SEL_W'(PIL_DEF);
      aux_ilim_o <= SEL_W'(AIL_DEF);
      fd_en_o    <= FD_DEF;
      det_en_o   <= DET_DEF;
    end else if (rst_part_i) begin
      neg_code_o <= NEG_W'(NEG_DEF);
      pos_code_o <= SEL_W'(POS_DEF);
      pos_ilim_o <= SEL_W'(PIL_DEF);
    end else if (wr_en_i) begin
      if (c >= NEG_LO && c <= NEG_HI)      neg_code_o <= NEG_W'(c);
      else if (c >= AUX_LO && c <= AUX_HI) aux_code_o <= AUX_W'(c - AUX_LO);
      else if (c == FD_ON)                 fd_en_o    <= 1'b1;
      else if (c == FD_OFF)                fd_en_o    <= 1'b0;
      else if (c == DET_ON)                det_en_o   <= 1'b1;
      else if (c == DET_OFF)               det_en_o   <= 1'b0;
      else if (c >= POS_LO && c <= POS_HI) pos_code_o <= SEL_W'(c - POS_LO);
      else if (c >= PIL_LO && c <= PIL_HI) pos_ilim_o <= SEL_W'(c - PIL_LO);
      else if (c >= AIL_LO && c <= AIL_HI) aux_ilim_o <= SEL_W'(c - AIL_LO);
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_all_i && !rst_part_i && (!wr_en_i || int'(cnt_i) > AIL_HI))
      |=> $stable({neg_code_o, aux_code_o, pos_code_o, pos_ilim_o, aux_ilim_o, fd_en_o, det_en_o}));

  p_full_dflt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_all_i |=> (aux_code_o == AUX_W'(AUX_DEF) && aux_ilim_o == SEL_W'(AIL_DEF) && fd_en_o == FD_DEF));

  p_neg_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(neg_code_o) >= NEG_LO && int'(neg_code_o) <= NEG_HI));
endmodule

// File: rtl/pulse_cfg_decoder.sv
module pulse_cfg_decoder
  import pcd_pkg::*;
#(
  parameter int OFF_US   = 400,
  parameter int STORE_US = 40,
  parameter int INIT_US  = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_us_i,
  input  logic             ctrl_i,
  input  logic             aux_en_i,
  output logic [NEG_W-1:0] neg_code_o,
  output logic [AUX_W-1:0] aux_code_o,
  output logic [SEL_W-1:0] pos_code_o,
  output logic [SEL_W-1:0] pos_ilim_o,
  output logic [SEL_W-1:0] aux_ilim_o,
  output logic             fd_en_o,
  output logic             det_en_o,
  output logic             rail_en_o
);
  localparam int IW = $clog2(INIT_US + 1);

  state_e           state_q;
  logic [IW-1:0]    init_q;
  logic             ctrl_q;
  logic             rise, low_full, high_full, shut, store;
  logic [CNT_W-1:0] pcnt;

  assign rise  = ctrl_i && !ctrl_q;
  assign shut  = (state_q != ST_OFF) && low_full;
  assign store = (state_q == ST_RUN) && high_full && (pcnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      init_q  <= '0;
      ctrl_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_i;
      if (shut) begin
        state_q <= rise ? ST_INIT : ST_OFF;
        init_q  <= '0;
      end else begin
        unique case (state_q)
          ST_OFF: if (rise) begin
            state_q <= ST_INIT;
            init_q  <= '0;
          end
          ST_INIT: if (tick_us_i) begin
            if (init_q == IW'(INIT_US - 1)) state_q <= ST_RUN;
            else                            init_q  <= init_q + IW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign rail_en_o = (state_q != ST_OFF);

  pcd_level_timer #(.LIMIT(OFF_US), .LEVEL(1'b0)) u_low_timer (
    .clk_i, .rst_ni, .tick_i(tick_us_i), .line_i(ctrl_i), .full_o(low_full)
  );

  pcd_level_timer #(.LIMIT(STORE_US), .LEVEL(1'b1)) u_high_timer (
    .clk_i, .rst_ni, .tick_i(tick_us_i), .line_i(ctrl_i), .full_o(high_full)
  );

  pcd_pulse_cnt #(.W(CNT_W)) u_pulse_cnt (
    .clk_i, .rst_ni,
    .inc_i (rise && state_q == ST_RUN),
    .clr_i (state_q != ST_RUN || store),
    .cnt_o (pcnt)
  );

  pcd_cfg_regs u_regs (
    .clk_i, .rst_ni,
    .rst_all_i  (state_q == ST_OFF && !aux_en_i),
    .rst_part_i (shut),
    .wr_en_i    (store),
    .cnt_i      (pcnt),
    .neg_code_o, .aux_code_o, .pos_code_o, .pos_ilim_o, .aux_ilim_o,
    .fd_en_o, .det_en_o
  );

  p_rail_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && rise) |=> rail_en_o);

  p_init_nocount_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |=> pcnt == '0);

  p_shut_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut && !rise) |=> !rail_en_o);

  p_commit_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store |=> pcnt == '0);
endmodule

// File: tb/pulse_cfg_decoder_test.sv
module pulse_cfg_decoder_test;
  localparam int OFF_T = 400, STORE_T = 40, INIT_T = 100;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ctrl = 1'b0, aux_en = 1'b0;
  logic [5:0] neg; logic [4:0] aux; logic [2:0] pos, pil, ail;
  logic fd, det, rail;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_cfg_decoder #(.OFF_US(OFF_T), .STORE_US(STORE_T), .INIT_US(INIT_T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .ctrl_i(ctrl), .aux_en_i(aux_en),
    .neg_code_o(neg), .aux_code_o(aux), .pos_code_o(pos), .pos_ilim_o(pil),
    .aux_ilim_o(ail), .fd_en_o(fd), .det_en_o(det), .rail_en_o(rail)
  );

  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  // behavioural reference
  int m_st, m_init, m_low, m_high, m_cnt, m_prev;
  int m_neg, m_aux, m_pos, m_pil, m_ail, m_fd, m_det;

  task automatic m_defaults();
    m_neg = 25; m_aux = 8; m_pos = 0; m_pil = 6; m_ail = 4; m_fd = 1; m_det = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_init = 0; m_low = 0; m_high = 0; m_cnt = 0; m_prev = 0;
      m_defaults();
    end else begin
      bit rise, shut, store;
      int st;
      rise  = ctrl && !m_prev;
      shut  = (m_st != 0) && (m_low == OFF_T);
      store = (m_st == 2) && (m_high == STORE_T) && (m_cnt != 0);
      if (m_st == 0 && !aux_en) m_defaults();
      else if (shut) begin m_neg = 25; m_pos = 0; m_pil = 6; end
      else if (store) begin
        if (m_cnt >= 1 && m_cnt <= 51) m_neg = m_cnt;
        else if (m_cnt <= 79) m_aux = m_cnt - 52;
        else if (m_cnt == 80) m_fd = 1;
        else if (m_cnt == 81) m_fd = 0;
        else if (m_cnt == 82) m_det = 1;
        else if (m_cnt == 83) m_det = 0;
        else if (m_cnt <= 90) m_pos = m_cnt - 84;
        else if (m_cnt <= 97) m_pil = m_cnt - 91;
        else if (m_cnt <= 104) m_ail = m_cnt - 98;
      end
      if (m_st != 2 || store) m_cnt = 0;
      else if (rise && m_cnt < 127) m_cnt++;
      st = m_st;
      if (shut) begin st = rise ? 1 : 0; m_init = 0; end
      else if (m_st == 0 && rise) begin st = 1; m_init = 0; end
      else if (m_st == 1 && tick) begin
        if (m_init == INIT_T - 1) st = 2; else m_init++;
      end
      m_st = st;
      if (ctrl) m_low = 0; else if (tick && m_low < OFF_T) m_low++;
      if (!ctrl) m_high = 0; else if (tick && m_high < STORE_T) m_high++;
      m_prev = ctrl;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model neg", neg, m_neg);
    chk("R3 model aux", aux, m_aux);
    chk("R6 model pos", pos, m_pos);
    chk("R7 model pil", pil, m_pil);
    chk("R8 model ail", ail, m_ail);
    chk("R4 model fd", fd, m_fd);
    chk("R5 model det", det, m_det);
    chk("R10 model rail", rail, (m_st != 0) ? 1 : 0);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) begin
      ctrl = 1'b0; wait_cyc(6);
      ctrl = 1'b1; wait_cyc(6);
    end
    wait_cyc(100);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    // R13 reset state
    chk("R13 neg", neg, 25); chk("R13 aux", aux, 8); chk("R13 pos", pos, 0);
    chk("R13 pil", pil, 6);  chk("R13 ail", ail, 4); chk("R13 fd", fd, 1);
    chk("R13 det", det, 0);  chk("R13 rail", rail, 0);
    aux_en = 1'b1;
    // R10 enable edge, pulses in init window ignored
    ctrl = 1'b1; wait_cyc(2);
    chk("R10 rail on", rail, 1);
    wait_cyc(20);
    for (int i = 0; i < 3; i++) begin ctrl = 1'b0; wait_cyc(6); ctrl = 1'b1; wait_cyc(6); end
    wait_cyc(300);
    chk("R10 init pulses ignored", neg, 25);
    // R1 R2
    burst(1);  chk("R1 R2 neg=1", neg, 1);
    burst(51); chk("R2 neg=51", neg, 51);
    burst(30); chk("R2 neg=30", neg, 30);
    // R3
    burst(52); chk("R3 aux=0", aux, 0);
    burst(79); chk("R3 aux=27", aux, 27);
    // R4
    burst(81); chk("R4 fd off", fd, 0);
    burst(80); chk("R4 fd on", fd, 1);
    // R5
    burst(82); chk("R5 det on", det, 1);
    burst(83); chk("R5 det off", det, 0);
    // R6
    burst(86); chk("R6 pos=2", pos, 2);
    burst(90); chk("R6 pos=6", pos, 6);
    // R7
    burst(93); chk("R7 pil=2", pil, 2);
    // R8
    burst(104); chk("R8 ail=6", ail, 6);
    burst(98);  chk("R8 ail=0", ail, 0);
    burst(99);  chk("R8 ail=1", ail, 1);
    // R9 out of range and saturation
    burst(110); chk("R9 >104 neg kept", neg, 30); chk("R9 >104 ail kept", ail, 1);
    burst(130); chk("R9 saturate neg kept", neg, 30); chk("R9 saturate aux kept", aux, 27);
    // R11 short low is a gap: acts as one pulse
    ctrl = 1'b0; wait_cyc(2 * (OFF_T - 100));
    ctrl = 1'b1; wait_cyc(100);
    chk("R11 gap rail kept", rail, 1); chk("R11 gap counted", neg, 1);
    burst(81); burst(82); burst(30);
    // R11 shutdown
    ctrl = 1'b0; wait_cyc(2 * OFF_T + 20);
    chk("R11 rail off", rail, 0); chk("R11 neg dflt", neg, 25);
    chk("R11 pos dflt", pos, 0);  chk("R11 pil dflt", pil, 6);
    chk("R11 aux kept", aux, 27); chk("R11 ail kept", ail, 1);
    chk("R11 fd kept", fd, 0);    chk("R11 det kept", det, 1);
    // R12 full reset
    aux_en = 1'b0; wait_cyc(2);
    chk("R12 aux dflt", aux, 8); chk("R12 ail dflt", ail, 4);
    chk("R12 fd dflt", fd, 1);   chk("R12 det dflt", det, 0);
    wait_cyc(4);
    finish_run();
  end
endmodule